// File: doc/BRIEF.md
# Store Instruction Execution Unit

This unit carries out one 32-bit store instruction per cycle. It accepts a word, halfword or byte store, in either an immediate-offset form or a register-offset form. The instruction word arrives with a valid strobe. The unit names three registers on its read port. The base register index comes from the field at bits [15:11], the data register index from bits [20:16], and the offset register index from bits [25:21]. The register values return in the same cycle.

From the base value plus the offset, the unit forms a byte address. One cycle later it presents a single write with byte enables to a 32-bit data memory. In that same cycle it pulses `done`, and `fault` comes with it. `fault` goes high when the access is misaligned or when the memory answers with an error.

The immediate is spread over two fields of the instruction. It is scaled by the access size. All six opcodes are parameters, so the core can pick its own opcode map.

Top module: `store_exec_unit`

## Requirements
- R1: An instruction whose opcode (bits [6:0]) matches none of the six store opcode parameters leaves `mem_we` and `done` low in the following cycle.
- R2: The read port indices are `rf_base_idx` = instr[15:11], `rf_data_idx` = instr[20:16] and `rf_off_idx` = instr[25:21], driven combinationally from `instr`.
- R3: In the immediate forms the 15-bit offset is {instr[31:21], instr[10:7]}. It is sign-extended, then shifted left by 2 for a word, by 1 for a halfword and by 0 for a byte.
- R4: `mem_addr` equals the base register value plus either the scaled immediate or the offset register value, modulo 2^32.
- R5: A word store drives `mem_be` = 4'b1111, and `mem_wdata` is the full data register value.
- R6: A halfword store drives `mem_be` = 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. Data register bits [15:0] appear in both halves of `mem_wdata`.
- R7: A byte store drives the single enable bit whose index is address bits [1:0]. Data register bits [7:0] appear in all four bytes of `mem_wdata`.
- R8: A word store to an address with bits [1:0] not zero, or a halfword store to an odd address, gives `fault` = 1 and `done` = 1 with `mem_we` = 0.
- R9: When `mem_fault` is high in the cycle of an issued write, `fault` is high in that cycle.
- R10: A store sampled with `instr_valid` at a clock edge produces its write, `done` and `fault` in the cycle after that edge. `done` then falls unless another store was sampled, and back-to-back stores are each completed.
- R11: While and right after reset (active-low `rst_n`), `mem_we`, `mem_be`, `done` and `fault` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Instruction word is presented this cycle |
| instr | input | 32 | Instruction word |
| rf_base_idx | output | 5 | Base register index |
| rf_data_idx | output | 5 | Data register index |
| rf_off_idx | output | 5 | Offset register index |
| rf_base_val | input | 32 | Base register value |
| rf_data_val | input | 32 | Data register value |
| rf_off_val | input | 32 | Offset register value |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the write |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_fault | input | 1 | Memory error response for the current write |
| done | output | 1 | Store completed this cycle |
| fault | output | 1 | Completed store faulted |

## Verification
On every cycle, the assertions check the lane shape of the byte enables for each access size. They also check that no write is issued to a misaligned word or halfword address, that `fault` never appears without `done`, and that `done` is always preceded by an accepted store. The bench scenarios are the only way to show the exact address arithmetic: the split and scaled immediate, negative offsets, and the register-offset sum. They also cover the replicated data pattern, the decoding of the distinct opcode parameters and the one-cycle latency.

// File: rtl/store_pkg.sv
package store_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } acc_size_e;

   typedef struct packed {
      logic      is_store;
      logic      use_reg;
      acc_size_e size;
   } st_dec_t;

endpackage

// File: rtl/store_decode.sv
module store_decode
   import store_pkg::*;
#(
   parameter int INSTR_W      = 32,
   parameter int DATA_W       = 32,
   parameter int OPC_W        = 7,
   parameter int IMM_W        = 15,
   parameter logic [OPC_W-1:0] OPC_WORD_IMM = 7'h18,
   parameter logic [OPC_W-1:0] OPC_WORD_REG = 7'h19,
   parameter logic [OPC_W-1:0] OPC_HALF_IMM = 7'h1d,
   parameter logic [OPC_W-1:0] OPC_HALF_REG = 7'h1a,
   parameter logic [OPC_W-1:0] OPC_BYTE_IMM = 7'h1b,
   parameter logic [OPC_W-1:0] OPC_BYTE_REG = 7'h1c
) (
   input  logic [INSTR_W-1:0] instr,
   output st_dec_t            dec,
   output logic [DATA_W-1:0]  imm_ext
);
   localparam int LO_W = 4;
   localparam int HI_W = IMM_W - LO_W;
   localparam int LO_POS = OPC_W;
   localparam int HI_POS = INSTR_W - HI_W;

   logic [OPC_W-1:0]  opc;
   logic [IMM_W-1:0]  imm_raw;
   logic [DATA_W-1:0] imm_sx;

   assign opc     = instr[OPC_W-1:0];
   assign imm_raw = {instr[HI_POS +: HI_W], instr[LO_POS +: LO_W]};
   assign imm_sx  = {{(DATA_W-IMM_W){imm_raw[IMM_W-1]}}, imm_raw};

   always_comb begin
      dec = '{is_store: 1'b1, use_reg: 1'b0, size: SZ_WORD};
      if      (opc == OPC_WORD_IMM) dec = '{1'b1, 1'b0, SZ_WORD};
      else if (opc == OPC_WORD_REG) dec = '{1'b1, 1'b1, SZ_WORD};
      else if (opc == OPC_HALF_IMM) dec = '{1'b1, 1'b0, SZ_HALF};
      else if (opc == OPC_HALF_REG) dec = '{1'b1, 1'b1, SZ_HALF};
      else if (opc == OPC_BYTE_IMM) dec = '{1'b1, 1'b0, SZ_BYTE};
      else if (opc == OPC_BYTE_REG) dec = '{1'b1, 1'b1, SZ_BYTE};
      else                          dec = '{1'b0, 1'b0, SZ_BYTE};
   end

   always_comb begin
      unique case (dec.size)
         SZ_WORD: imm_ext = imm_sx << 2;
         SZ_HALF: imm_ext = imm_sx << 1;
         default: imm_ext = imm_sx;
      endcase
   end

endmodule

// File: rtl/store_agen.sv
module store_agen
   import store_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] imm_ext,
   input  logic [DATA_W-1:0] off_val,
   input  logic              use_reg,
   input  acc_size_e         size,
   output logic [DATA_W-1:0] addr,
   output logic              misaligned
);
   logic [DATA_W-1:0] offset;

   assign offset = use_reg ? off_val : imm_ext;
   assign addr   = base_val + offset;

   always_comb begin
      unique case (size)
         SZ_WORD: misaligned = |addr[1:0];
         SZ_HALF: misaligned = addr[0];
         default: misaligned = 1'b0;
      endcase
   end

endmodule

// File: rtl/store_lanes.sv
module store_lanes
   import store_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int LANES = DATA_W / 8
) (
   input  acc_size_e         size,
   input  logic [1:0]        addr_lo,
   input  logic [DATA_W-1:0] src,
   output logic [LANES-1:0]  be,
   output logic [DATA_W-1:0] wdata
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam logic [1:0] LIDX = 2'(i);
      logic       lane_be;
      logic [7:0] lane_d;

      always_comb begin
         unique case (size)
            SZ_WORD: begin
               lane_be = 1'b1;
               lane_d  = src[i*8 +: 8];
            end
            SZ_HALF: begin
               lane_be = (LIDX[1] == addr_lo[1]);
               lane_d  = src[(i%2)*8 +: 8];
            end
            default: begin
               lane_be = (LIDX == addr_lo);
               lane_d  = src[7:0];
            end
         endcase
      end

      assign be[i]          = lane_be;
      assign wdata[i*8 +: 8] = lane_d;
   end

endmodule

// File: rtl/store_exec_unit.sv
module store_exec_unit
   import store_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int DATA_W  = 32,
   parameter int REG_W   = 5,
   parameter int OPC_W   = 7,
   parameter int IMM_W   = 15,
   parameter logic [OPC_W-1:0] OPC_WORD_IMM = 7'h18,
   parameter logic [OPC_W-1:0] OPC_WORD_REG = 7'h19,
   parameter logic [OPC_W-1:0] OPC_HALF_IMM = 7'h1d,
   parameter logic [OPC_W-1:0] OPC_HALF_REG = 7'h1a,
   parameter logic [OPC_W-1:0] OPC_BYTE_IMM = 7'h1b,
   parameter logic [OPC_W-1:0] OPC_BYTE_REG = 7'h1c,
   localparam int LANES = DATA_W / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic [REG_W-1:0]   rf_base_idx,
   output logic [REG_W-1:0]   rf_data_idx,
   output logic [REG_W-1:0]   rf_off_idx,
   input  logic [DATA_W-1:0]  rf_base_val,
   input  logic [DATA_W-1:0]  rf_data_val,
   input  logic [DATA_W-1:0]  rf_off_val,
   output logic               mem_we,
   output logic [DATA_W-1:0]  mem_addr,
   output logic [LANES-1:0]   mem_be,
   input  logic               mem_fault,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic               done,
   output logic               fault
);
   localparam int BASE_POS = OPC_W + 4;
   localparam int DATA_POS = BASE_POS + REG_W;
   localparam int OFF_POS  = DATA_POS + REG_W;

   if (DATA_W != 32) begin : g_bad_data_w
      $error("store_exec_unit: DATA_W must be 32");
   end
   if (INSTR_W != OPC_W + 4 + 2*REG_W + (IMM_W - 4)) begin : g_bad_layout
      $error("store_exec_unit: instruction fields do not fill INSTR_W");
   end
   if (OFF_POS + REG_W > INSTR_W) begin : g_bad_off_pos
      $error("store_exec_unit: offset register field exceeds INSTR_W");
   end
   if (OPC_WORD_IMM == OPC_WORD_REG || OPC_WORD_IMM == OPC_HALF_IMM ||
       OPC_WORD_IMM == OPC_HALF_REG || OPC_WORD_IMM == OPC_BYTE_IMM ||
       OPC_WORD_IMM == OPC_BYTE_REG || OPC_WORD_REG == OPC_HALF_IMM ||
       OPC_WORD_REG == OPC_HALF_REG || OPC_WORD_REG == OPC_BYTE_IMM ||
       OPC_WORD_REG == OPC_BYTE_REG || OPC_HALF_IMM == OPC_HALF_REG ||
       OPC_HALF_IMM == OPC_BYTE_IMM || OPC_HALF_IMM == OPC_BYTE_REG ||
       OPC_HALF_REG == OPC_BYTE_IMM || OPC_HALF_REG == OPC_BYTE_REG ||
       OPC_BYTE_IMM == OPC_BYTE_REG) begin : g_dup_opcode
      $error("store_exec_unit: store opcodes must be distinct");
   end

   st_dec_t           dec;
   logic [DATA_W-1:0] imm_ext;
   logic [DATA_W-1:0] addr_d;
   logic              misal_d;
   logic [LANES-1:0]  be_d;
   logic [DATA_W-1:0] wdata_d;

   assign rf_base_idx = instr[BASE_POS +: REG_W];
   assign rf_data_idx = instr[DATA_POS +: REG_W];
   assign rf_off_idx  = instr[OFF_POS  +: REG_W];

   store_decode #(
      .INSTR_W(INSTR_W), .DATA_W(DATA_W), .OPC_W(OPC_W), .IMM_W(IMM_W),
      .OPC_WORD_IMM(OPC_WORD_IMM), .OPC_WORD_REG(OPC_WORD_REG),
      .OPC_HALF_IMM(OPC_HALF_IMM), .OPC_HALF_REG(OPC_HALF_REG),
      .OPC_BYTE_IMM(OPC_BYTE_IMM), .OPC_BYTE_REG(OPC_BYTE_REG)
   ) u_decode (
      .instr   (instr),
      .dec     (dec),
      .imm_ext (imm_ext)
   );

   store_agen #(.DATA_W(DATA_W)) u_agen (
      .base_val   (rf_base_val),
      .imm_ext    (imm_ext),
      .off_val    (rf_off_val),
      .use_reg    (dec.use_reg),
      .size       (dec.size),
      .addr       (addr_d),
      .misaligned (misal_d)
   );

   store_lanes #(.DATA_W(DATA_W)) u_lanes (
      .size    (dec.size),
      .addr_lo (addr_d[1:0]),
      .src     (rf_data_val),
      .be      (be_d),
      .wdata   (wdata_d)
   );

   logic              stage_vld;
   logic              misal_q;
   acc_size_e         size_q;
   logic [DATA_W-1:0] addr_q;
   logic [LANES-1:0]  be_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_vld <= 1'b0;
         misal_q   <= 1'b0;
         size_q    <= SZ_BYTE;
         addr_q    <= '0;
         be_q      <= '0;
         wdata_q   <= '0;
      end else begin
         stage_vld <= instr_valid && dec.is_store;
         if (instr_valid && dec.is_store) begin
            misal_q <= misal_d;
            size_q  <= dec.size;
            addr_q  <= addr_d;
            be_q    <= be_d;
            wdata_q <= wdata_d;
         end
      end
   end

   assign mem_we    = stage_vld && !misal_q;
   assign mem_addr  = addr_q;
   assign mem_be    = mem_we ? be_q : '0;
   assign mem_wdata = wdata_q;
   assign done      = stage_vld;
   assign fault     = stage_vld && (misal_q || mem_fault);

   AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> (!mem_we && mem_be == '0));                                 // R1
   AST_WORD_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && size_q == SZ_WORD) |-> (mem_be == '1));                    // R5
   AST_HALF_TWO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && size_q == SZ_HALF) |-> (mem_be == 4'b0011 || mem_be == 4'b1100)); // R6
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && size_q == SZ_BYTE) |-> ($countones(mem_be) == 1));         // R7
   AST_NO_MISALIGNED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !((size_q == SZ_WORD && mem_addr[1:0] != 2'b00) ||
                   (size_q == SZ_HALF && mem_addr[0])));                    // R8
   AST_FAULT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> done);                                                      // R9
   AST_DONE_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(instr_valid && dec.is_store));                         // R10

endmodule

// File: tb/store_exec_unit_tb.sv
module store_exec_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [4:0]  rf_base_idx, rf_data_idx, rf_off_idx;
   logic [31:0] rf_base_val, rf_data_val, rf_off_val;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic        mem_fault = 1'b0;
   logic [31:0] mem_wdata;
   logic        done, fault;

   logic [31:0] regs [32];
   int checks = 0;
   int failures = 0;

   localparam logic [6:0] OP_WI = 7'h18, OP_WR = 7'h19, OP_HI = 7'h1d,
                          OP_HR = 7'h1a, OP_BI = 7'h1b, OP_BR = 7'h1c;

   always #5 clk = ~clk;

   assign rf_base_val = regs[rf_base_idx];
   assign rf_data_val = regs[rf_data_idx];
   assign rf_off_val  = regs[rf_off_idx];

   store_exec_unit #(
      .OPC_WORD_IMM(OP_WI), .OPC_WORD_REG(OP_WR), .OPC_HALF_IMM(OP_HI),
      .OPC_HALF_REG(OP_HR), .OPC_BYTE_IMM(OP_BI), .OPC_BYTE_REG(OP_BR)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
      .rf_base_idx(rf_base_idx), .rf_data_idx(rf_data_idx), .rf_off_idx(rf_off_idx),
      .rf_base_val(rf_base_val), .rf_data_val(rf_data_val), .rf_off_val(rf_off_val),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be), .mem_fault(mem_fault),
      .mem_wdata(mem_wdata), .done(done), .fault(fault)
   );

   function automatic logic [31:0] enc_imm(logic [6:0] op, logic [4:0] b,
                                           logic [4:0] d, logic [14:0] imm);
      return {imm[14:4], d, b, imm[3:0], op};
   endfunction

   function automatic logic [31:0] enc_reg(logic [6:0] op, logic [4:0] b,
                                           logic [4:0] d, logic [4:0] o);
      return {6'b0, o, d, b, 4'b0, op};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one instruction, then sample the cycle after the capturing edge.
   task automatic run(string tag, logic [31:0] ins, logic mf, logic e_we,
                      logic [31:0] e_addr, logic [3:0] e_be, logic [31:0] e_wd,
                      logic e_done, logic e_fault);
      @(negedge clk);
      instr = ins;
      instr_valid = 1'b1;
      mem_fault = mf;
      @(negedge clk);
      instr_valid = 1'b0;
      chk({tag, " we"}, 32'(mem_we), 32'(e_we));
      chk({tag, " be"}, 32'(mem_be), 32'(e_be));
      chk({tag, " done"}, 32'(done), 32'(e_done));
      chk({tag, " fault"}, 32'(fault), 32'(e_fault));
      if (e_we) begin
         chk({tag, " addr"}, mem_addr, e_addr);
         chk({tag, " wdata"}, mem_wdata, e_wd);
      end
      mem_fault = 1'b0;
   endtask

   task automatic t_reset();
      chk("R11 we", 32'(mem_we), 0);
      chk("R11 be", 32'(mem_be), 0);
      chk("R11 done", 32'(done), 0);
      chk("R11 fault", 32'(fault), 0);
   endtask

   task automatic t_index();
      @(negedge clk);
      instr = enc_reg(OP_WR, 5'd9, 5'd17, 5'd30);
      #1;
      chk("R2 base idx", 32'(rf_base_idx), 9);
      chk("R2 data idx", 32'(rf_data_idx), 17);
      chk("R2 off idx", 32'(rf_off_idx), 30);
   endtask

   task automatic t_word();
      run("R3 R5 word imm +8", enc_imm(OP_WI, 2, 3, 15'd2), 0, 1,
          32'h0000_1008, 4'hF, 32'hDEAD_BEEF, 1, 0);
      run("R3 word imm -4", enc_imm(OP_WI, 2, 3, 15'h7FFF), 0, 1,
          32'h0000_0FFC, 4'hF, 32'hDEAD_BEEF, 1, 0);
      run("R3 word imm split field", enc_imm(OP_WI, 2, 3, 15'h0011), 0, 1,
          32'h0000_1044, 4'hF, 32'hDEAD_BEEF, 1, 0);
      run("R4 word reg", enc_reg(OP_WR, 2, 3, 4), 0, 1,
          32'h0000_1020, 4'hF, 32'hDEAD_BEEF, 1, 0);
   endtask

   task automatic t_half();
      run("R6 half imm upper", enc_imm(OP_HI, 2, 5, 15'd3), 0, 1,
          32'h0000_1006, 4'b1100, 32'hABCD_ABCD, 1, 0);
      run("R6 half reg lower", enc_reg(OP_HR, 2, 5, 7), 0, 1,
          32'h0000_1000, 4'b0011, 32'hABCD_ABCD, 1, 0);
   endtask

   task automatic t_byte();
      run("R7 byte imm -1", enc_imm(OP_BI, 2, 5, 15'h7FFF), 0, 1,
          32'h0000_0FFF, 4'b1000, 32'hCDCD_CDCD, 1, 0);
      run("R7 byte reg +1", enc_reg(OP_BR, 2, 5, 8), 0, 1,
          32'h0000_1001, 4'b0010, 32'hCDCD_CDCD, 1, 0);
      run("R7 R3 byte imm unscaled", enc_imm(OP_BI, 2, 5, 15'd2), 0, 1,
          32'h0000_1002, 4'b0100, 32'hCDCD_CDCD, 1, 0);
   endtask

   task automatic t_misalign();
      run("R8 word misaligned", enc_reg(OP_WR, 2, 3, 6), 0, 0,
          0, 4'b0, 0, 1, 1);
      run("R8 half odd", enc_reg(OP_HR, 2, 5, 8), 0, 0,
          0, 4'b0, 0, 1, 1);
   endtask

   task automatic t_memfault();
      run("R9 mem fault", enc_imm(OP_WI, 2, 3, 15'd0), 1, 1,
          32'h0000_1000, 4'hF, 32'hDEAD_BEEF, 1, 1);
   endtask

   task automatic t_nonstore();
      run("R1 opcode 0x33", enc_imm(7'h33, 2, 3, 15'd0), 0, 0,
          0, 4'b0, 0, 0, 0);
      run("R1 opcode 0x17", enc_imm(7'h17, 2, 3, 15'd0), 0, 0,
          0, 4'b0, 0, 0, 0);
   endtask

   task automatic t_timing();
      @(negedge clk);
      instr = enc_imm(OP_WI, 2, 3, 15'd1);
      instr_valid = 1'b1;
      @(negedge clk);
      chk("R10 first done", 32'(done), 1);
      chk("R10 first addr", mem_addr, 32'h0000_1004);
      instr = enc_imm(OP_BI, 2, 5, 15'd3);
      @(negedge clk);
      instr_valid = 1'b0;
      chk("R10 second done", 32'(done), 1);
      chk("R10 second addr", mem_addr, 32'h0000_1003);
      chk("R10 second be", 32'(mem_be), 32'h8);
      @(negedge clk);
      chk("R10 done falls", 32'(done), 0);
      chk("R10 we falls", 32'(mem_we), 0);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) regs[i] = 32'h0;
      regs[2] = 32'h0000_1000;
      regs[3] = 32'hDEAD_BEEF;
      regs[4] = 32'h0000_0020;
      regs[5] = 32'h1234_ABCD;
      regs[6] = 32'h0000_0002;
      regs[7] = 32'h0000_0000;
      regs[8] = 32'h0000_0001;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_index();
      t_word();
      t_half();
      t_byte();
      t_misalign();
      t_memfault();
      t_nonstore();
      t_timing();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule